// File: doc/BRIEF.md
# Raw Character Comma Aligner

This block finds the 10-bit character boundary in an unaligned receive stream when the line decoder is bypassed. Each clock it takes one 10-bit word from a deserializer. The first bit received sits in bit 0. The block keeps the last two words, which gives 20 bits of history. It checks all ten bit offsets for a comma whose first seven bits in reception order are 0, 0, 1, 1, 1, 1, 1. The last three bits of the comma can take any value.

Once the boundary is known, the block puts out one raw, undecoded 10-bit character per cycle. It also raises a flag on every cycle whose aligned character holds the comma. The two top bits of the character go out on the pins that carry the control-character flag and the error flag when decoding is enabled. An enable input decides whether a comma seen at a different offset may move the boundary. The first comma after reset always sets the boundary.

Top module: `raw_comma_aligner`

## Requirements
- R1: Each output character is the raw 10 received bits starting at the locked offset, with bit 0 being the earliest received bit. Bits 7..0 drive `rxData`, bit 8 drives `rxKBit` and bit 9 drives `rxErrBit`.
- R2: A comma is a character whose bits 0..6 are, in order, 0,0,1,1,1,1,1 (bits [6:0] = 7'b1111100). Bits 7..9 are ignored. The inverted form and near misses are not commas.
- R3: After reset, `charValid` is low and all data outputs and `commaDet` are zero until the first comma is found. The first comma sets the boundary whatever the level of `resyncEn`.
- R4: While locked and with `resyncEn` high, a comma at a different offset moves the boundary to that offset. The character holding that comma is itself output aligned.
- R5: While locked and with `resyncEn` low, the offset is held and commas at other offsets are ignored. A comma at the held offset is still flagged.
- R6: `commaDet` is high exactly in the cycles where the valid output character matches the comma of R2.
- R7: A character whose first bit lies in the input word sampled at clock edge n appears on the outputs after edge n+2.
- R8: When several offsets hold a comma in the same cycle, the current offset is kept if it is one of them. Otherwise the lowest offset wins.
- R9: Once `charValid` is high it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawIn | input | 10 | Unaligned received word, bit 0 earliest |
| resyncEn | input | 1 | Allows a new comma offset to move the boundary |
| rxData | output | 8 | Aligned character bits 7..0 |
| rxKBit | output | 1 | Aligned character bit 8 |
| rxErrBit | output | 1 | Aligned character bit 9 |
| commaDet | output | 1 | Output character holds the comma |
| charValid | output | 1 | A boundary has been locked |

## Verification
The assertions assume the following about the inputs:
- Reset is held low for at least one clock edge before any checking starts.
- `resyncEn` is a steady level that is sampled only at the clock edge.
- `rawIn` is fully settled by each rising edge.

The bench respects these assumptions. It starts every scenario with a reset lasting several cycles. It changes `rawIn` and `resyncEn` only on the falling edge. It builds each bit stream so that commas appear only at the offsets the scenario intends.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  localparam int ALN_CHAR_W = 10;
  localparam int ALN_OFF_W  = $clog2(ALN_CHAR_W);

  // strobes from the control to the datapath
  typedef struct packed {
    logic                 valid;  // output character is aligned
    logic [ALN_OFF_W-1:0] sel;    // offset used for this cycle
  } alnStrobe_t;

endpackage

// File: rtl/align_datapath.sv
module align_datapath
  import aligner_pkg::*;
#(
  parameter int CHAR_W  = ALN_CHAR_W,
  parameter int PAT_LEN = 7,
  parameter logic [PAT_LEN-1:0] PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] rawIn,
  input  alnStrobe_t        strobe,
  output logic [CHAR_W-1:0] hitVec,
  output logic [CHAR_W-1:0] charQ,
  output logic              detQ,
  output logic              validQ
);

  localparam int WIN_W = 2 * CHAR_W;

  logic [CHAR_W-1:0] newWord;
  logic [CHAR_W-1:0] oldWord;
  logic [WIN_W-1:0]  window;
  logic [CHAR_W-1:0] cand [CHAR_W];
  logic [CHAR_W-1:0] selChar;
  logic              selIsComma;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newWord <= '0;
      oldWord <= '0;
    end else begin
      newWord <= rawIn;
      oldWord <= newWord;
    end
  end

  // older word in low bits: bit order equals reception order
  assign window = {newWord, oldWord};

  for (genvar k = 0; k < CHAR_W; k++) begin : g_off
    assign cand[k]   = window[k +: CHAR_W];
    assign hitVec[k] = (cand[k][PAT_LEN-1:0] == PAT);
  end

  always_comb begin
    selChar = '0;
    for (int k = 0; k < CHAR_W; k++) begin
      if (strobe.sel == ALN_OFF_W'(k)) selChar = cand[k];
    end
  end

  assign selIsComma = (selChar[PAT_LEN-1:0] == PAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charQ  <= '0;
      detQ   <= 1'b0;
      validQ <= 1'b0;
    end else begin
      charQ  <= strobe.valid ? selChar : '0;
      detQ   <= strobe.valid && selIsComma;
      validQ <= strobe.valid;
    end
  end

endmodule

// File: rtl/align_control.sv
module align_control
  import aligner_pkg::*;
#(
  parameter int CHAR_W = ALN_CHAR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CHAR_W-1:0]    hitVec,
  input  logic                 resyncEn,
  output alnStrobe_t           strobe,
  output logic [ALN_OFF_W-1:0] offsetQ,
  output logic                 lockedQ
);

  logic [ALN_OFF_W-1:0] lowOff;
  logic                 anyHit;
  logic                 curHit;
  logic                 take;

  // lowest set hit wins
  always_comb begin
    lowOff = '0;
    for (int k = CHAR_W - 1; k >= 0; k--) begin
      if (hitVec[k]) lowOff = ALN_OFF_W'(k);
    end
  end

  always_comb begin
    curHit = 1'b0;
    for (int k = 0; k < CHAR_W; k++) begin
      if (offsetQ == ALN_OFF_W'(k)) curHit = hitVec[k];
    end
  end

  assign anyHit = |hitVec;
  assign take   = anyHit && (!lockedQ || (resyncEn && !curHit));

  assign strobe.valid = lockedQ || take;
  assign strobe.sel   = take ? lowOff : offsetQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
      lockedQ <= 1'b0;
    end else begin
      if (take) offsetQ <= lowOff;
      lockedQ <= lockedQ || take;
    end
  end

endmodule

// File: rtl/raw_comma_aligner.sv
module raw_comma_aligner
  import aligner_pkg::*;
#(
  parameter int CHAR_W  = ALN_CHAR_W,
  parameter int PAT_LEN = 7,
  parameter logic [PAT_LEN-1:0] PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] rawIn,
  input  logic              resyncEn,
  output logic [CHAR_W-3:0] rxData,
  output logic              rxKBit,
  output logic              rxErrBit,
  output logic              commaDet,
  output logic              charValid
);

  alnStrobe_t           strobe;
  logic [CHAR_W-1:0]    hitVec;
  logic [CHAR_W-1:0]    charQ;
  logic [ALN_OFF_W-1:0] curOffset;
  logic                 lockedQ;

  align_control #(.CHAR_W(CHAR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .hitVec   (hitVec),
    .resyncEn (resyncEn),
    .strobe   (strobe),
    .offsetQ  (curOffset),
    .lockedQ  (lockedQ)
  );

  align_datapath #(.CHAR_W(CHAR_W), .PAT_LEN(PAT_LEN), .PAT(PAT)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (rawIn),
    .strobe (strobe),
    .hitVec (hitVec),
    .charQ  (charQ),
    .detQ   (commaDet),
    .validQ (charValid)
  );

  assign rxData   = charQ[CHAR_W-3:0];
  assign rxKBit   = charQ[CHAR_W-2];
  assign rxErrBit = charQ[CHAR_W-1];

endmodule

// File: rtl/raw_comma_aligner_chk.sv
module raw_comma_aligner_chk
  import aligner_pkg::*;
#(
  parameter int CHAR_W  = ALN_CHAR_W,
  parameter int PAT_LEN = 7,
  parameter logic [PAT_LEN-1:0] PAT = 7'b1111100
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 resyncEn,
  input logic [CHAR_W-3:0]    rxData,
  input logic                 rxKBit,
  input logic                 rxErrBit,
  input logic                 commaDet,
  input logic                 charValid,
  input logic [ALN_OFF_W-1:0] curOffset,
  input logic                 lockedQ
);

  logic [CHAR_W-1:0] outChar;
  assign outChar = {rxErrBit, rxKBit, rxData};

  p_zero_when_invalid_r3: assert property (@(posedge clk) disable iff (!rstN)
    !charValid |-> (outChar == '0 && !commaDet));

  p_valid_means_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    charValid |-> lockedQ);

  p_hold_offset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockedQ && !resyncEn) |=> $stable(curOffset));

  p_det_pattern_r6: assert property (@(posedge clk) disable iff (!rstN)
    commaDet |-> (charValid && outChar[PAT_LEN-1:0] == PAT));

  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> charValid);

endmodule

bind raw_comma_aligner raw_comma_aligner_chk #(
  .CHAR_W(CHAR_W), .PAT_LEN(PAT_LEN), .PAT(PAT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .resyncEn  (resyncEn),
  .rxData    (rxData),
  .rxKBit    (rxKBit),
  .rxErrBit  (rxErrBit),
  .commaDet  (commaDet),
  .charValid (charValid),
  .curOffset (curOffset),
  .lockedQ   (lockedQ)
);

// File: tb/raw_comma_aligner_tb_top.sv
module raw_comma_aligner_tb_top;

  localparam logic [9:0] COMMA  = 10'h17C; // 0,0,1,1,1,1,1,0,1,0
  localparam logic [9:0] COMMAB = 10'h3FC; // comma, tail 1,1,1
  localparam logic [9:0] COMMAZ = 10'h07C; // comma, tail 0,0,0
  localparam logic [9:0] NEAR   = 10'h03C; // 0,0,1,1,1,1,0,...
  localparam logic [9:0] INVC   = 10'h083; // 1,1,0,0,0,0,0,1,0,0
  localparam logic [9:0] DATA   = 10'h155;
  localparam logic [9:0] D2     = 10'h255;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       resyncEn = 1'b0;
  logic [9:0] rawIn = '0;
  logic [7:0] rxData;
  logic       rxKBit, rxErrBit, commaDet, charValid;

  always #10 clk = ~clk;

  raw_comma_aligner dut_i (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .resyncEn(resyncEn),
    .rxData(rxData), .rxKBit(rxKBit), .rxErrBit(rxErrBit),
    .commaDet(commaDet), .charValid(charValid)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic       streamBits [0:1023];
  int         nBits;
  logic [9:0] logChar [0:99];
  logic       logDet  [0:99];
  logic       logVal  [0:99];

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic checkLog(input string req, input int idx, input logic [9:0] expChar,
                          input logic expDet, input logic expVal);
    check(req, $sformatf("char[%0d]", idx), {6'b0, logChar[idx]}, {6'b0, expChar});
    check(req, $sformatf("det[%0d]", idx), {15'b0, logDet[idx]}, {15'b0, expDet});
    check(req, $sformatf("valid[%0d]", idx), {15'b0, logVal[idx]}, {15'b0, expVal});
  endtask

  task automatic clearStream();
    nBits = 0;
  endtask

  task automatic addBits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      streamBits[nBits] = v[i];
      nBits++;
    end
  endtask

  task automatic addChar(input logic [9:0] v);
    addBits({6'b0, v}, 10);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN  = 1'b0;
    rawIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // word i is sampled at edge i; log[i] holds outputs after edge i
  task automatic runStream();
    int nW;
    logic [9:0] w;
    nW = (nBits + 9) / 10 + 3;
    for (int i = 0; i <= nW; i++) begin
      if (i > 0) @(negedge clk);
      if (i > 0) begin
        logChar[i-1] = {rxErrBit, rxKBit, rxData};
        logDet[i-1]  = commaDet;
        logVal[i-1]  = charValid;
      end
      for (int b = 0; b < 10; b++)
        w[b] = (10 * i + b < nBits) ? streamBits[10 * i + b] : 1'b0;
      rawIn = w;
    end
    @(negedge clk);
    rawIn = '0;
  endtask

  task automatic testResetNoComma();
    resyncEn = 1'b1;
    doReset();
    check("R3", "valid after reset", {15'b0, charValid}, 16'h0);
    check("R3", "char after reset", {6'b0, rxErrBit, rxKBit, rxData}, 16'h0);
    clearStream();
    addChar(DATA); addChar(D2); addChar(DATA); addChar(D2);
    runStream();
    for (int i = 0; i < 6; i++) checkLog("R3", i, 10'h0, 1'b0, 1'b0);
  endtask

  task automatic testFirstLock();
    resyncEn = 1'b0;
    doReset();
    clearStream();
    addChar(DATA); addChar(DATA); addBits(16'h0, 3);
    addChar(COMMA); addChar(D2); addChar(DATA);
    runStream();
    checkLog("R3", 3, 10'h0, 1'b0, 1'b0);
    checkLog("R7", 4, COMMA, 1'b1, 1'b1);
    checkLog("R1", 5, D2, 1'b0, 1'b1);
    checkLog("R9", 6, DATA, 1'b0, 1'b1);
    check("R1", "k bit of comma", {15'b0, logChar[4][8]}, 16'h1);
    check("R1", "err bit of d2", {15'b0, logChar[5][9]}, 16'h1);
  endtask

  task automatic buildShiftStream();
    clearStream();
    addBits(16'h0, 3); addChar(COMMA); addChar(D2); addChar(D2);
    addBits(16'h0, 4); addChar(COMMA); addChar(D2); addChar(D2);
    addBits(16'h0, 6); addChar(COMMA); addChar(DATA);
  endtask

  task automatic testRealign();
    resyncEn = 1'b1;
    doReset();
    buildShiftStream();
    runStream();
    checkLog("R3", 2, COMMA, 1'b1, 1'b1);
    checkLog("R4", 4, D2, 1'b0, 1'b1);
    checkLog("R4", 5, COMMA, 1'b1, 1'b1);
    checkLog("R4", 6, D2, 1'b0, 1'b1);
    checkLog("R4", 9, COMMA, 1'b1, 1'b1);
    checkLog("R4", 10, DATA, 1'b0, 1'b1);
  endtask

  task automatic testHold();
    resyncEn = 1'b0;
    doReset();
    buildShiftStream();
    runStream();
    checkLog("R5", 3, D2, 1'b0, 1'b1);
    checkLog("R5", 5, 10'h3C0, 1'b0, 1'b1);
    checkLog("R5", 6, DATA, 1'b0, 1'b1);
    checkLog("R5", 9, COMMA, 1'b1, 1'b1);
  endtask

  task automatic testPatterns();
    resyncEn = 1'b1;
    doReset();
    clearStream();
    addChar(COMMA); addChar(COMMAB); addChar(NEAR);
    addChar(INVC); addChar(COMMAZ); addChar(DATA);
    runStream();
    checkLog("R2", 3, COMMAB, 1'b1, 1'b1);
    checkLog("R2", 4, NEAR, 1'b0, 1'b1);
    checkLog("R2", 5, INVC, 1'b0, 1'b1);
    checkLog("R6", 6, COMMAZ, 1'b1, 1'b1);
    checkLog("R6", 7, DATA, 1'b0, 1'b1);
  endtask

  task automatic testKeepCurrent();
    resyncEn = 1'b1;
    doReset();
    clearStream();
    addBits(16'h0, 7); addChar(COMMA); addChar(10'h3E5);
    addChar(COMMA); addChar(DATA);
    runStream();
    checkLog("R8", 2, COMMA, 1'b1, 1'b1);
    checkLog("R8", 4, COMMA, 1'b1, 1'b1);
    checkLog("R8", 5, DATA, 1'b0, 1'b1);
  endtask

  task automatic testLowestFirst();
    resyncEn = 1'b0;
    doReset();
    clearStream();
    addBits(16'h0, 2); addBits(16'h7C, 7); addBits(16'h0, 2);
    addBits(16'h1F, 5); addChar(DATA); addChar(DATA); addChar(DATA);
    runStream();
    checkLog("R8", 1, 10'h0, 1'b0, 1'b0);
    checkLog("R8", 2, 10'h27C, 1'b1, 1'b1);
    checkLog("R3", 3, 10'h15F, 1'b0, 1'b1);
  endtask

  initial begin
    testResetNoComma();
    testFirstLock();
    testRealign();
    testHold();
    testPatterns();
    testKeepCurrent();
    testLowestFirst();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R1..all: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule